// File: doc/BRIEF.md
# Repeating Multiframe-Aligned Message Transmitter

This block sends a message of 1 to 64 bytes, written by a processor, over and over on a data link. The link is carried in chosen bit positions of a time slot inside a framed serial stream. Each pass of the message starts at a transmit multiframe start. In T1 mode a multiframe is 24 frames. In E1 mode it is 16 frames. The framer supplies a pulse at the start of each frame and a strobe for each bit position of the chosen slot. The block answers each strobe one cycle later with a data-link bit and a valid flag.

The processor writes bytes into a shadow copy of the message and then pulses a commit together with the length. The committed message waits. It takes over at the first multiframe start where no pass is in progress, so the bit stream stays continuous across a changeover. Between passes, and before any message exists, the enabled positions carry 1s. An 8-bit mask chooses the slot positions that carry link data. When the slot is the T1 framing-bit position, the mask is bypassed and every strobe carries one bit.

Top module: `msg_loop_tx`

## Requirements
- R1: After reset, dl_valid is 0 and dl_bit is 1. The first frame_start after reset is a multiframe start in both modes.
- R2: With fbit_sel=0, a bit_stb cycle with bit_idx=i gives dl_valid=1 in the next cycle exactly when bit_mask[i]=1. Bit_idx 0 is the first bit of the slot and bit_idx 7 is the eighth. Any mask combination is allowed. A cycle without bit_stb gives dl_valid=0 in the next cycle.
- R3: With fbit_sel=1, every bit_stb gives dl_valid=1 in the next cycle whatever bit_mask holds, so each frame carries one bit.
- R4: Message bits go out with byte 0 first and each byte least significant bit first. Only valid positions take a bit from the message.
- R5: len_in, sampled when commit is pulsed, sets the message length from 1 to 64 bytes. A pass ends after the last bit of byte len-1.
- R6: A pass starts only at a multiframe start. With e1_mode=0 that is every 24th frame_start, and with e1_mode=1 every 16th.
- R7: After a pass ends, valid positions carry dl_bit=1 until the next multiframe start. The same message then repeats from byte 0.
- R8: wr_en stores wr_data at byte wr_addr of the shadow message. Writes and commit leave the output of the active message unchanged. A committed message starts at the first multiframe start that finds no pass in progress.
- R9: A pass still in progress at a multiframe start continues to its end. A pending message waits for a later multiframe start.
- R10: While no message has ever been committed and started, valid positions carry dl_bit=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one byte into the shadow message |
| wr_addr | input | ADDR_W (6) | Byte index of the write |
| wr_data | input | 8 | Byte value to write |
| len_in | input | LEN_W (7) | Message length in bytes (1..64), taken at commit |
| commit | input | 1 | Marks the shadow message pending |
| frame_start | input | 1 | One-cycle pulse at the start of each frame, never together with bit_stb |
| e1_mode | input | 1 | 0: 24-frame multiframe, 1: 16-frame multiframe |
| bit_stb | input | 1 | Strobe for one bit position of the selected slot |
| bit_idx | input | 3 | Position of the strobed bit in the slot, 0 = first |
| bit_mask | input | 8 | Enable per slot bit position |
| fbit_sel | input | 1 | Slot is the T1 framing-bit position: mask bypassed |
| dl_bit | output | 1 | Data-link bit for the last strobe |
| dl_valid | output | 1 | dl_bit carries link data this cycle |

## Verification
The assertions check the relation between a strobe, the mask and the valid flag on every cycle. They also check that a pass begins only on a multiframe start, that the byte pointer stays below the length, and that positions outside a pass carry 1s. Only the bench scenarios can show the bit order, the repetition period in each mode, and that a long pass runs through a multiframe start. They also cover the wait of a committed message and its takeover at the correct frame.

// File: rtl/msg_loop_pkg.sv
package msg_loop_pkg;
  localparam int SLOT_BITS = 8;
  typedef logic [SLOT_BITS-1:0] slot_byte_t;
endpackage

// File: rtl/msg_mf_timer.sv
module msg_mf_timer #(
  parameter int T1_FRAMES = 24,
  parameter int E1_FRAMES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic e1_mode,
  output logic mf_start
);
  localparam int MAXF  = (T1_FRAMES > E1_FRAMES) ? T1_FRAMES : E1_FRAMES;
  localparam int CNT_W = $clog2(MAXF);

  logic [CNT_W-1:0] fcnt;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign last     = e1_mode ? CNT_W'(E1_FRAMES - 1) : CNT_W'(T1_FRAMES - 1);
  assign at_last  = (fcnt >= last);
  assign mf_start = frame_start & at_last;

  // Counter parks on the highest frame number so the first frame is frame 0.
  always_ff @(posedge clk) begin
    if (rst)              fcnt <= CNT_W'(MAXF - 1);
    else if (frame_start) fcnt <= at_last ? '0 : fcnt + CNT_W'(1);
  end
endmodule

// File: rtl/msg_bank_ram.sv
module msg_bank_ram #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic                          wbank,
  input  logic [ADDR_W-1:0]             waddr,
  input  msg_loop_pkg::slot_byte_t      wdata,
  input  logic                          rbank,
  input  logic [ADDR_W-1:0]             raddr,
  output msg_loop_pkg::slot_byte_t      rdata
);
  localparam int WORDS = 2 * DEPTH;

  msg_loop_pkg::slot_byte_t mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= wdata;
  end

  assign rdata = mem[{rbank, raddr}];
endmodule

// File: rtl/msg_slot_gate.sv
module msg_slot_gate (
  input  logic                     bit_stb,
  input  logic [2:0]               bit_idx,
  input  logic [7:0]               bit_mask,
  input  logic                     fbit_sel,
  input  msg_loop_pkg::slot_byte_t cur_byte,
  input  logic [2:0]               bit_ptr,
  output logic                     take,
  output logic                     cur_bit
);
  assign take    = bit_stb & (fbit_sel | bit_mask[bit_idx]);
  assign cur_bit = cur_byte[bit_ptr];
endmodule

// File: rtl/msg_loop_tx.sv
module msg_loop_tx #(
  parameter int MAX_BYTES = 64,
  parameter int T1_FRAMES = 24,
  parameter int E1_FRAMES = 16,
  parameter int ADDR_W    = $clog2(MAX_BYTES),
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              commit,
  input  logic              frame_start,
  input  logic              e1_mode,
  input  logic              bit_stb,
  input  logic [2:0]        bit_idx,
  input  logic [7:0]        bit_mask,
  input  logic              fbit_sel,
  output logic              dl_bit,
  output logic              dl_valid
);
  logic                     mf_start;
  logic                     take;
  logic                     cur_bit;
  msg_loop_pkg::slot_byte_t cur_byte;

  logic                     act_bank;
  logic [LEN_W-1:0]         act_len;
  logic [LEN_W-1:0]         pend_len;
  logic                     pend;
  logic                     has_msg;
  logic                     running;
  logic [ADDR_W-1:0]        byte_ptr;
  logic [2:0]               bit_ptr;
  logic                     last_byte;

  msg_mf_timer #(.T1_FRAMES(T1_FRAMES), .E1_FRAMES(E1_FRAMES)) u_timer (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .e1_mode(e1_mode), .mf_start(mf_start)
  );

  msg_bank_ram #(.DEPTH(MAX_BYTES), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_en), .wbank(~act_bank), .waddr(wr_addr),
    .wdata(wr_data), .rbank(act_bank), .raddr(byte_ptr), .rdata(cur_byte)
  );

  msg_slot_gate u_gate (
    .bit_stb(bit_stb), .bit_idx(bit_idx), .bit_mask(bit_mask),
    .fbit_sel(fbit_sel), .cur_byte(cur_byte), .bit_ptr(bit_ptr),
    .take(take), .cur_bit(cur_bit)
  );

  assign last_byte = ({1'b0, byte_ptr} == (act_len - LEN_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_bank <= 1'b0;
      act_len  <= LEN_W'(1);
      pend_len <= LEN_W'(1);
      pend     <= 1'b0;
      has_msg  <= 1'b0;
      running  <= 1'b0;
      byte_ptr <= '0;
      bit_ptr  <= '0;
      dl_bit   <= 1'b1;
      dl_valid <= 1'b0;
    end else begin
      dl_valid <= take;
      if (take) dl_bit <= running ? cur_bit : 1'b1;

      if (commit) begin
        pend     <= 1'b1;
        pend_len <= len_in;
      end

      if (mf_start && !running) begin
        byte_ptr <= '0;
        bit_ptr  <= '0;
        if (pend) begin
          act_bank <= ~act_bank;
          act_len  <= pend_len;
          pend     <= 1'b0;
          has_msg  <= 1'b1;
          running  <= 1'b1;
        end else if (has_msg) begin
          running  <= 1'b1;
        end
      end else if (take && running) begin
        bit_ptr <= bit_ptr + 3'd1;
        if (bit_ptr == 3'd7) begin
          if (last_byte) begin
            running  <= 1'b0;
            byte_ptr <= '0;
          end else begin
            byte_ptr <= byte_ptr + ADDR_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/msg_loop_tx_chk.sv
module msg_loop_tx_chk #(
  parameter int ADDR_W = 6,
  parameter int LEN_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_stb,
  input logic [2:0]        bit_idx,
  input logic [7:0]        bit_mask,
  input logic              fbit_sel,
  input logic              dl_bit,
  input logic              dl_valid,
  input logic              running,
  input logic              mf_start,
  input logic [ADDR_W-1:0] byte_ptr,
  input logic [LEN_W-1:0]  act_len
);
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    bit_stb && !fbit_sel && !bit_mask[bit_idx] |=> !dl_valid);

  a_r2_enabled_valid: assert property (@(posedge clk) disable iff (rst)
    bit_stb && !fbit_sel && bit_mask[bit_idx] |=> dl_valid);

  a_r2_no_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> !dl_valid);

  a_r3_fbit_valid: assert property (@(posedge clk) disable iff (rst)
    bit_stb && fbit_sel |=> dl_valid);

  a_r7_idle_ones: assert property (@(posedge clk) disable iff (rst)
    bit_stb && (fbit_sel || bit_mask[bit_idx]) && !running |=> dl_bit);

  a_r6_start_on_mf: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(mf_start));

  a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, byte_ptr} < act_len);
endmodule

bind msg_loop_tx msg_loop_tx_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_idx(bit_idx),
  .bit_mask(bit_mask), .fbit_sel(fbit_sel), .dl_bit(dl_bit),
  .dl_valid(dl_valid), .running(running), .mf_start(mf_start),
  .byte_ptr(byte_ptr), .act_len(act_len)
);

// File: tb/sim_msg_loop_tx.sv
module sim_msg_loop_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] len_in = 7'd1;
  logic       commit = 1'b0;
  logic       frame_start = 1'b0;
  logic       e1_mode = 1'b0;
  logic       bit_stb = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [7:0] bit_mask = 8'hFF;
  logic       fbit_sel = 1'b0;
  logic       dl_bit;
  logic       dl_valid;

  int errors = 0;
  int checks = 0;
  int fno = 0;
  logic [7:0] mbuf [64];

  // Stimulus table: {expected valid count, mask}
  localparam logic [11:0] VEC [6] = '{12'h8FF, 12'h101, 12'h180,
                                      12'h4AA, 12'h40F, 12'h000};

  always #4 clk = ~clk;

  msg_loop_tx u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .len_in(len_in), .commit(commit),
    .frame_start(frame_start), .e1_mode(e1_mode), .bit_stb(bit_stb),
    .bit_idx(bit_idx), .bit_mask(bit_mask), .fbit_sel(fbit_sel),
    .dl_bit(dl_bit), .dl_valid(dl_valid)
  );

  function automatic logic [7:0] m2(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] mt(input int i);
    return 8'hC3 ^ 8'(i * 17);
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s frame %0d: actual %h expected %h", req, fno, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; frame_start = 1'b0; bit_stb = 1'b0; commit = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    fno = 0;
  endtask

  task automatic load(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'(i); wr_data = mbuf[i];
    end
    @(negedge clk);
    wr_en = 1'b0; commit = 1'b1; len_in = 7'(len);
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic do_frame(input int nstb, input logic [2:0] idx0,
                          output logic [7:0] bits, output logic [7:0] vm);
    bits = '0; vm = '0;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    for (int i = 0; i < nstb; i++) begin
      bit_idx = idx0 + 3'(i);
      bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      bits[i] = dl_bit;
      vm[i]   = dl_valid;
    end
    @(negedge clk);
    fno++;
  endtask

  task automatic frame_byte(input string req, input logic [7:0] exp);
    logic [7:0] b, v;
    do_frame(8, 3'd0, b, v);
    check(req, {v, b}, {8'hFF, exp});
  endtask

  task automatic skip_to(input int target);
    logic [7:0] b, v;
    while (fno < target) do_frame(8, 3'd0, b, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b, v, eb;
    int sp, cnt;
    // T1 sequence
    do_reset();
    check("R1 valid", 32'(dl_valid), 32'd0);
    check("R1 bit", 32'(dl_bit), 32'd1);
    frame_byte("R10 idle ones", 8'hFF);             // frame 0
    mbuf[0] = 8'hA5; mbuf[1] = 8'h3C;
    load(2);
    frame_byte("R8 pending waits", 8'hFF);          // frame 1
    skip_to(24);
    frame_byte("R4 R6 byte0 at mf", 8'hA5);         // 24
    frame_byte("R5 byte1", 8'h3C);                  // 25
    frame_byte("R7 idle after pass", 8'hFF);        // 26
    skip_to(47);
    frame_byte("R7 idle before mf", 8'hFF);         // 47
    frame_byte("R7 repeat", 8'hA5);                 // 48
    frame_byte("R7 repeat byte1", 8'h3C);           // 49
    for (int i = 0; i < 30; i++) mbuf[i] = m2(i);
    load(30);
    frame_byte("R8 old msg idle", 8'hFF);           // 50
    skip_to(72);
    frame_byte("R8 takeover", m2(0));               // 72
    frame_byte("R5 long byte1", m2(1));             // 73
    skip_to(80);
    mbuf[0] = 8'h0F;
    load(1);
    skip_to(96);
    frame_byte("R9 pass continues", m2(24));        // 96
    skip_to(101);
    frame_byte("R5 last byte", m2(29));             // 101
    frame_byte("R7 idle after long", 8'hFF);        // 102
    skip_to(120);
    frame_byte("R8 new msg at mf", 8'h0F);          // 120
    frame_byte("R7 len1 idle", 8'hFF);              // 121
    skip_to(144);
    frame_byte("R7 len1 repeat", 8'h0F);            // 144

    // Mask table walk
    do_reset();
    for (int i = 0; i < 8; i++) mbuf[i] = mt(i);
    load(8);
    sp = 0;
    for (int k = 0; k < 6; k++) begin
      bit_mask = VEC[k][7:0];
      do_frame(8, 3'd0, b, v);
      check("R2 valid positions", 32'(v), 32'(VEC[k][7:0]));
      cnt = 0;
      eb = '0;
      for (int i = 0; i < 8; i++) begin
        if (v[i]) cnt++;
        if (VEC[k][i]) begin
          eb[i] = mbuf[sp / 8][sp % 8];
          sp++;
        end
      end
      check("R2 valid count", 32'(cnt), 32'(VEC[k][11:8]));
      check("R4 lsb first data", 32'(b & VEC[k][7:0]), 32'(eb));
    end
    bit_mask = 8'hFF;

    // E1 sequence
    do_reset();
    e1_mode = 1'b1;
    mbuf[0] = 8'h81;
    load(1);
    frame_byte("R6 e1 first", 8'h81);               // 0
    frame_byte("R7 e1 idle", 8'hFF);                // 1
    skip_to(15);
    frame_byte("R6 e1 frame15 idle", 8'hFF);        // 15
    frame_byte("R6 e1 16-frame repeat", 8'h81);     // 16
    e1_mode = 1'b0;

    // Framing-bit slot sequence
    do_reset();
    fbit_sel = 1'b1;
    bit_mask = 8'h00;
    mbuf[0] = 8'hB4;
    load(1);
    eb = '0;
    cnt = 0;
    for (int f = 0; f < 8; f++) begin
      do_frame(1, 3'd3, b, v);
      eb[f] = b[0];
      if (v[0]) cnt++;
    end
    check("R3 one bit per frame", 32'(cnt), 32'd8);
    check("R3 R4 fbit data", 32'(eb), 32'hB4);
    do_frame(1, 3'd3, b, v);
    check("R7 fbit idle", 32'({v[0], b[0]}), 32'b11);
    while (fno < 24) do_frame(1, 3'd3, b, v);
    do_frame(1, 3'd3, b, v);
    check("R6 fbit repeat", 32'({v[0], b[0]}), 32'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule